// File: doc/BRIEF.md
# LCD Frame Clock and Blink Generator

This block turns a fast LCD kernel clock into the slower timing events that a segment display controller needs. It divides in two stages, entirely with clock enables in the kernel clock domain. The first stage divides by a power of two. The second stage divides that rate by a whole number from 16 to 31. The result is a one-cycle frame enable that the waveform sequencer steps on.

On top of the frame rate the block keeps a blink phase level. The phase flips after a selectable number of frames. While the phase is high (the "off" half of a blink), a combinational flag reports whether the pixel currently addressed by segment and common index should be blanked. Which pixels blink depends on the blink mode: none, one pixel, one segment column, or every pixel.

Whenever a division or blink-rate code changes, the counter it governs restarts from zero. The next period is therefore a clean, full period, never a stretched or shortened one.

Top module: `lcd_frame_clk`

## Requirements
- R1: `ps_en` is a one-cycle pulse every 2^`ps_code` kernel cycles while `ps_code` is held; code 0 holds it high on every cycle and code 15 gives a period of 32768 cycles.
- R2: `frame_en` is a one-cycle pulse every (16 + `div_code`) × 2^`ps_code` kernel cycles, and it is only ever high in the cycle right after a `ps_en` pulse.
- R3: `blink_phase` toggles once every 8 × 2^`blink_rate` frame enables (rate codes 0..7 give 8..1024 frames), and it changes only in the cycle after a `frame_en` pulse.
- R4: While `rst_n` is low and just after its release, `ps_en`, `frame_en`, `blink_phase` and `pixel_blank` are all 0.
- R5: With `blink_mode` = 2'b00, `pixel_blank` stays 0 for every pixel in either phase.
- R6: With `blink_mode` = 2'b01, in the off phase `pixel_blank` is 1 only for `seg_idx` = 0 and `com_idx` = 0.
- R7: With `blink_mode` = 2'b10, in the off phase `pixel_blank` is 1 for `seg_idx` = 0 on any `com_idx`, and 0 for every other segment.
- R8: With `blink_mode` = 2'b11, in the off phase `pixel_blank` is 1 for every pixel.
- R9: While `blink_phase` is 0, `pixel_blank` is 0 in every mode.
- R10: When `ps_code` changes, no `ps_en` pulse appears in the next cycle. The first pulse after the change comes 2^(new code) + 1 cycles after the new code is applied. `div_code` and `blink_rate` changes likewise restart their own counters.
- R11: `pixel_blank` follows `seg_idx`, `com_idx` and `blink_mode` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | LCD kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_code | input | PS_W (4) | Power-of-two prescale code |
| div_code | input | DIV_W (4) | Second-stage divide code, ratio 16 + code |
| blink_mode | input | 2 | Blink pixel selection: 00 off, 01 one pixel, 10 segment 0, 11 all |
| blink_rate | input | RATE_W (3) | Blink rate code, frames per toggle = 8 << code |
| seg_idx | input | SEG_W (6) | Segment index of the pixel being queried |
| com_idx | input | COM_W (3) | Common index of the pixel being queried |
| ps_en | output | 1 | One-cycle enable at the prescaled rate |
| frame_en | output | 1 | One-cycle enable at the frame rate |
| blink_phase | output | 1 | Blink phase, high during the off half |
| pixel_blank | output | 1 | Addressed pixel is blanked now |

## Verification
The bench uses the default parameters: 4-bit prescale and divide codes, a 3-bit rate code, 6-bit segment and 3-bit common indices. With these defaults the full prescale range is reachable within the run, including the 32768-cycle period of the top code. The slowest blink rate (1024 frames) is measured at the fastest frame rate. Pixel sweeps cover segment 0, nonzero segments, and the extreme common lines.

// File: rtl/lcd_frame_clk.sv
module lcd_frame_clk #(
  parameter int PS_W   = 4,
  parameter int DIV_W  = 4,
  parameter int RATE_W = 3,
  parameter int SEG_W  = 6,
  parameter int COM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PS_W-1:0]   ps_code,
  input  logic [DIV_W-1:0]  div_code,
  input  logic [1:0]        blink_mode,
  input  logic [RATE_W-1:0] blink_rate,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic [COM_W-1:0]  com_idx,
  output logic              ps_en,
  output logic              frame_en,
  output logic              blink_phase,
  output logic              pixel_blank
);
  localparam int PCW = (1 << PS_W) - 1;
  localparam int DCW = DIV_W + 1;
  localparam int BCW = 3 + (1 << RATE_W) - 1;

  logic [PS_W-1:0]   ps_q;
  logic [DIV_W-1:0]  div_q;
  logic [RATE_W-1:0] rate_q;
  logic [PCW-1:0]    pcnt, plim;
  logic [DCW-1:0]    dcnt, dlim;
  logic [BCW-1:0]    bcnt, blim;
  logic              ps_chg, div_chg, rate_chg, hit;

  assign ps_chg   = ps_code != ps_q;
  assign div_chg  = div_code != div_q;
  assign rate_chg = blink_rate != rate_q;
  assign plim = PCW'((32'd1 << ps_code) - 32'd1);
  assign dlim = DCW'((1 << DIV_W) - 1) + DCW'(div_code);
  assign blim = BCW'((32'd8 << blink_rate) - 32'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ps_q <= '0; pcnt <= '0; ps_en <= 1'b0;
    end else begin
      ps_q <= ps_code;
      if (ps_chg) begin
        pcnt <= '0; ps_en <= 1'b0;
      end else if (pcnt == plim) begin
        pcnt <= '0; ps_en <= 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1; ps_en <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; dcnt <= '0; frame_en <= 1'b0;
    end else begin
      div_q <= div_code;
      frame_en <= 1'b0;
      if (div_chg) dcnt <= '0;
      else if (ps_en) begin
        if (dcnt == dlim) begin
          dcnt <= '0; frame_en <= 1'b1;
        end else dcnt <= dcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rate_q <= '0; bcnt <= '0; blink_phase <= 1'b0;
    end else begin
      rate_q <= blink_rate;
      if (rate_chg) bcnt <= '0;
      else if (frame_en) begin
        if (bcnt == blim) begin
          bcnt <= '0; blink_phase <= ~blink_phase;
        end else bcnt <= bcnt + 1'b1;
      end
    end

  always_comb
    case (blink_mode)
      2'b01:   hit = (seg_idx == '0) && (com_idx == '0);
      2'b10:   hit = (seg_idx == '0);
      2'b11:   hit = 1'b1;
      default: hit = 1'b0;
    endcase

  assign pixel_blank = blink_phase & hit;

  // R1
  ps_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_en && ps_code != '0 && $stable(ps_code)) |=> !ps_en);
  // R2
  frame_after_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |-> $past(ps_en));
  // R3
  phase_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_phase != $past(blink_phase)) |-> $past(frame_en));
  // R10
  ps_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_code != $past(ps_code)) |=> !ps_en);
  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_mode == 2'b00) |-> !pixel_blank);
  // R9
  phase_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_phase |-> !pixel_blank);
endmodule

// File: tb/lcd_frame_clk_bench.sv
`timescale 1ns/1ps
module lcd_frame_clk_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ps_code = '0, div_code = '0;
  logic [1:0] blink_mode = '0;
  logic [2:0] blink_rate = '0;
  logic [5:0] seg_idx = '0;
  logic [2:0] com_idx = '0;
  logic ps_en, frame_en, blink_phase, pixel_blank;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lcd_frame_clk u_lcd_frame_clk (
    .clk(clk), .rst_n(rst_n), .ps_code(ps_code), .div_code(div_code),
    .blink_mode(blink_mode), .blink_rate(blink_rate), .seg_idx(seg_idx),
    .com_idx(com_idx), .ps_en(ps_en), .frame_en(frame_en),
    .blink_phase(blink_phase), .pixel_blank(pixel_blank));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sel(input int which);
    return which == 0 ? ps_en : frame_en;
  endfunction

  task automatic pulse_gap(input int which, output int n);
    while (!sel(which)) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!sel(which));
  endtask

  task automatic toggle_gap(output int n);
    logic p;
    p = blink_phase;
    while (blink_phase == p) @(negedge clk);
    p = blink_phase; n = 0;
    do begin @(negedge clk); n++; end while (blink_phase == p);
  endtask

  task automatic t_reset;
    chk("R4 ps_en", ps_en, 0);
    chk("R4 frame_en", frame_en, 0);
    chk("R4 blink_phase", blink_phase, 0);
    blink_mode = 2'b11;
    #0.1 chk("R4 pixel_blank", pixel_blank, 0);
    blink_mode = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R4 phase after release", blink_phase, 0);
  endtask

  task automatic t_prescale;
    int n;
    int codes [4] = '{1, 5, 0, 15};
    foreach (codes[i]) begin
      ps_code = 4'(codes[i]);
      @(negedge clk);
      pulse_gap(0, n);
      chk($sformatf("R1 ps period code %0d", codes[i]), n, 1 << codes[i]);
    end
    ps_code = 0;
    @(negedge clk);
  endtask

  task automatic t_divider;
    int n;
    int pc [3] = '{0, 0, 2};
    int dc [3] = '{0, 15, 3};
    foreach (pc[i]) begin
      ps_code = 4'(pc[i]); div_code = 4'(dc[i]);
      @(negedge clk);
      pulse_gap(1, n);
      chk("R2 frame period", n, (16 + dc[i]) << pc[i]);
      @(negedge clk);
      chk("R2 frame single cycle", frame_en, 0);
    end
    ps_code = 0; div_code = 0;
    @(negedge clk);
  endtask

  task automatic t_restart;
    int n;
    ps_code = 4'd2;
    @(negedge clk);
    while (!ps_en) @(negedge clk);
    @(negedge clk);
    ps_code = 4'd3;
    n = 0;
    do begin @(negedge clk); n++; end while (!ps_en);
    chk("R10 first ps_en after change", n, 9);
    ps_code = 0;
    @(negedge clk);
  endtask

  task automatic t_blink;
    int n;
    int rc [3] = '{0, 2, 7};
    foreach (rc[i]) begin
      blink_rate = 3'(rc[i]);
      @(negedge clk);
      toggle_gap(n);
      chk($sformatf("R3 toggle gap rate %0d", rc[i]), n, (8 << rc[i]) * 16);
    end
    blink_rate = 0;
    @(negedge clk);
  endtask

  task automatic t_masks;
    int sg [4] = '{0, 0, 7, 63};
    int cm [4] = '{0, 7, 0, 3};
    int e;
    while (!blink_phase) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      blink_mode = 2'(m);
      foreach (sg[i]) begin
        seg_idx = 6'(sg[i]); com_idx = 3'(cm[i]);
        #0.1;
        case (m)
          0: e = 0;
          1: e = (sg[i] == 0 && cm[i] == 0);
          2: e = (sg[i] == 0);
          default: e = 1;
        endcase
        case (m)
          0: chk("R5 mode 00 blank", pixel_blank, e);
          1: chk("R6 mode 01 blank", pixel_blank, e);
          2: chk("R7 mode 10 blank", pixel_blank, e);
          default: chk("R8 R11 mode 11 blank", pixel_blank, e);
        endcase
      end
      @(negedge clk);
    end
    while (blink_phase) @(negedge clk);
    blink_mode = 2'b11; seg_idx = 6'd5; com_idx = 3'd3;
    #0.1 chk("R9 on phase no blank", pixel_blank, 0);
    seg_idx = 0; com_idx = 0;
    #0.1 chk("R9 on phase seg0", pixel_blank, 0);
    blink_mode = 2'b00;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_prescale();
    t_divider();
    t_restart();
    t_blink();
    t_masks();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule